// File: doc/BRIEF.md
# Sector Write-Lock Guard

This block keeps one volatile write-lock bit for every erase sector of a 512K-word memory. It decides, one cycle after each request, whether a program, sector-erase or whole-array erase may go ahead. The address space is split asymmetrically. The lower part holds fifteen large sectors of 32K words each. The highest 32K words hold eight small 4K-word boot sectors, which gives 23 sectors in all. Any word address inside a sector names that sector.

The command decoder sends a one-cycle lock command with an address. The guard then sets the lock bit of the sector that contains that address. Nothing but reset clears a lock bit. Program and erase requests share the same address port. For each request the guard returns a response that either grants it or rejects it. A rejected request also raises an error indication, which the status logic reads. While the device is in identification mode, a read at word offset 2 inside any sector returns that sector's lock bit.

Top module: `sector_lock_guard`

## Requirements
- R1: After reset every lock bit is clear, so an identification read at offset 2 of every sector returns `id_lock`=0.
- R2: A word address whose bits [18:15] are below 15 lies in large sector number bits[18:15]. Any other address lies in small sector 15 + bits[14:12].
- R3: A `cmd_lock` pulse locks only the sector that contains `op_addr`, whatever the offset of `op_addr` inside that sector.
- R4: A program request (`req_prog`) aimed at a locked sector gives `rsp_valid`=1, `rsp_err`=1 and `rsp_ok`=0 in the cycle after the request.
- R5: A sector-erase request (`req_erase`) aimed at a locked sector is rejected in the same way as in R4.
- R6: A program or sector-erase request aimed at an unlocked sector gives `rsp_valid`=1, `rsp_ok`=1 and `rsp_err`=0 in the cycle after the request.
- R7: A whole-array erase request (`req_chip`) is rejected when at least one sector is locked, and granted only when no sector is locked.
- R8: A lock command aimed at a sector that is already locked changes no lock bit.
- R9: `id_lock` equals the lock bit of the addressed sector only when `id_mode`=1 and `rd_addr` sits at word offset 2 inside its sector. In every other case it is 0.
- R10: Lock bits stay set through idle cycles and later requests. Only reset clears them.
- R11: Exactly one response cycle follows each request cycle. `rsp_valid` stays 0 in cycles that follow no request. A request that comes in the same cycle as a lock command is judged against the lock state from before that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_lock | input | 1 | Lock the sector that contains `op_addr` |
| req_prog | input | 1 | Program request at `op_addr` |
| req_erase | input | 1 | Sector-erase request at `op_addr` |
| req_chip | input | 1 | Whole-array erase request |
| op_addr | input | 19 | Word address for lock commands and requests |
| id_mode | input | 1 | Identification read mode is active |
| rd_addr | input | 19 | Word address of the current read |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_ok | output | 1 | The request is granted |
| rsp_err | output | 1 | The request is rejected (error flag) |
| id_lock | output | 1 | Lock bit shown at an identification read |

## Verification
A lock bit that is set wrongly, or that is lost, shows at the ports in two ways. It shows at once through a combinational identification read at offset 2 of that sector. It also shows one cycle after any program or erase request aimed at that sector, where the grant and reject outputs come out the wrong way round. A sector decoder with a bad boundary shows up as a lock that lands in a neighbouring sector. So every lock command is followed by identification reads of all 23 sectors, and each sector is probed at an offset other than its base.

// File: rtl/slk_pkg.sv
package slk_pkg;

  typedef struct packed {
    logic valid;
    logic ok;
    logic err;
  } slk_rsp_t;

endpackage

// File: rtl/slk_sector_decode.sv
module slk_sector_decode #(
  parameter int ADDR_W     = 19,
  parameter int BIG_LOG2   = 15,
  parameter int SMALL_LOG2 = 12,
  parameter int N_BIG      = 15,
  parameter int IDX_W      = 5,
  parameter int STAT_OFS   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              stat_hit
);
  localparam int HI_W  = ADDR_W - BIG_LOG2;
  localparam int SUB_W = BIG_LOG2 - SMALL_LOG2;

  logic [HI_W-1:0]  hi;
  logic [SUB_W-1:0] sub;
  logic             in_boot;

  always_comb begin
    hi      = addr[ADDR_W-1:BIG_LOG2];
    sub     = addr[BIG_LOG2-1:SMALL_LOG2];
    in_boot = (hi >= HI_W'(N_BIG));
    if (in_boot) begin
      idx      = IDX_W'(N_BIG) + IDX_W'(sub);
      stat_hit = (addr[SMALL_LOG2-1:0] == SMALL_LOG2'(STAT_OFS));
    end else begin
      idx      = IDX_W'(hi);
      stat_hit = (addr[BIG_LOG2-1:0] == BIG_LOG2'(STAT_OFS));
    end
  end
endmodule

// File: rtl/slk_lock_bank.sv
module slk_lock_bank #(
  parameter int N_SECT = 23,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  output logic [N_SECT-1:0] lock_vec
);
  logic [N_SECT-1:0] lock_d;
  logic [N_SECT-1:0] lock_q;

  for (genvar g = 0; g < N_SECT; g++) begin : g_bit
    always_comb lock_d[g] = lock_q[g] | (set_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q[g] <= 1'b0;
      else if (set_en) lock_q[g] <= lock_d[g];
    end
  end

  assign lock_vec = lock_q;
endmodule

// File: rtl/sector_lock_guard.sv
module sector_lock_guard #(
  parameter int ADDR_W     = 19,
  parameter int BIG_LOG2   = 15,
  parameter int SMALL_LOG2 = 12,
  parameter int N_BIG      = 15,
  parameter int N_SMALL    = 8,
  parameter int STAT_OFS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_lock,
  input  logic              req_prog,
  input  logic              req_erase,
  input  logic              req_chip,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_err,
  output logic              id_lock
);
  import slk_pkg::*;

  localparam int N_SECT = N_BIG + N_SMALL;
  localparam int IDX_W  = $clog2(N_SECT);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0]  op_idx, rd_idx;
  logic              op_stat_unused, rd_stat_hit;
  logic [N_SECT-1:0] lock_vec;

  slk_sector_decode #(
    .ADDR_W(ADDR_W), .BIG_LOG2(BIG_LOG2), .SMALL_LOG2(SMALL_LOG2),
    .N_BIG(N_BIG), .IDX_W(IDX_W), .STAT_OFS(STAT_OFS)
  ) u_op_dec (
    .addr(op_addr), .idx(op_idx), .stat_hit(op_stat_unused)
  );

  slk_sector_decode #(
    .ADDR_W(ADDR_W), .BIG_LOG2(BIG_LOG2), .SMALL_LOG2(SMALL_LOG2),
    .N_BIG(N_BIG), .IDX_W(IDX_W), .STAT_OFS(STAT_OFS)
  ) u_rd_dec (
    .addr(rd_addr), .idx(rd_idx), .stat_hit(rd_stat_hit)
  );

  slk_lock_bank #(.N_SECT(N_SECT), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .set_en(cmd_lock),
    .set_idx(op_idx), .lock_vec(lock_vec)
  );

  // request judgement against the current (pre-command) lock state
  logic     any_req, deny;
  slk_rsp_t rsp_d, rsp_q;

  always_comb begin
    any_req   = req_prog | req_erase | req_chip;
    deny      = (req_chip && (|lock_vec)) ||
                ((req_prog || req_erase) && lock_vec[op_idx]);
    rsp_d.valid = any_req;
    rsp_d.ok    = any_req & ~deny;
    rsp_d.err   = any_req & deny;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rsp_q <= '0;
    else             rsp_q <= rsp_d;
  end

  assign rsp_valid = rsp_q.valid;
  assign rsp_ok    = rsp_q.ok;
  assign rsp_err   = rsp_q.err;
  assign id_lock   = id_mode & rd_stat_hit & lock_vec[rd_idx];
endmodule

// File: rtl/slk_guard_chk.sv
module slk_guard_chk #(
  parameter int N_SECT = 23,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_lock,
  input logic [IDX_W-1:0]  op_idx,
  input logic [N_SECT-1:0] lock_vec,
  input logic              req_prog,
  input logic              req_erase,
  input logic              req_chip,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_err,
  input logic              id_mode,
  input logic              id_lock
);
  // R10
  locks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

  // R3
  lock_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lock |=> lock_vec[$past(op_idx)]);

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prog || req_erase || req_chip) |=> rsp_valid);

  // R11
  no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_prog || req_erase || req_chip) |=> !rsp_valid);

  // R7
  chip_locked_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_chip && (|lock_vec)) |=> (rsp_err && !rsp_ok));

  // R6
  rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_ok, rsp_err}));

  // R9
  id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> !id_lock);
endmodule

bind sector_lock_guard slk_guard_chk #(.N_SECT(N_SECT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_lock(cmd_lock), .op_idx(op_idx),
  .lock_vec(lock_vec), .req_prog(req_prog), .req_erase(req_erase),
  .req_chip(req_chip), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
  .rsp_err(rsp_err), .id_mode(id_mode), .id_lock(id_lock)
);

// File: tb/tb_sector_lock_guard.sv
module tb_sector_lock_guard;
  logic        clk = 1'b0;
  logic        rst_n, cmd_lock, req_prog, req_erase, req_chip, id_mode;
  logic [18:0] op_addr, rd_addr;
  logic        rsp_valid, rsp_ok, rsp_err, id_lock;
  int          n_run = 0, n_fail = 0;
  bit          model_lock [23];

  always #5 clk = ~clk;

  sector_lock_guard dut (
    .clk(clk), .rst_n(rst_n), .cmd_lock(cmd_lock), .req_prog(req_prog),
    .req_erase(req_erase), .req_chip(req_chip), .op_addr(op_addr),
    .id_mode(id_mode), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_err(rsp_err), .id_lock(id_lock)
  );

  function automatic int base_of(int s);
    return (s < 15) ? s * 32768 : 15 * 32768 + (s - 15) * 4096;
  endfunction
  function automatic int size_of(int s);
    return (s < 15) ? 32768 : 4096;
  endfunction
  function automatic bit any_locked();
    for (int s = 0; s < 23; s++) if (model_lock[s]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_lock = 0; req_prog = 0; req_erase = 0; req_chip = 0;
    id_mode = 0; op_addr = '0; rd_addr = '0;
    for (int s = 0; s < 23; s++) model_lock[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic id_read(int addr, bit mode, bit exp, string req);
    id_mode = mode; rd_addr = 19'(addr);
    #1 check(req, int'(id_lock), int'(exp));
    id_mode = 1'b0;
  endtask

  task automatic sweep_ids(string req);
    for (int s = 0; s < 23; s++) id_read(base_of(s) + 2, 1'b1, model_lock[s], req);
  endtask

  task automatic lock_at(int addr);
    @(negedge clk);
    cmd_lock = 1'b1; op_addr = 19'(addr);
    @(negedge clk);
    cmd_lock = 1'b0;
    for (int s = 0; s < 23; s++)
      if (addr >= base_of(s) && addr < base_of(s) + size_of(s)) model_lock[s] = 1'b1;
  endtask

  // kind: 0 program, 1 sector erase, 2 whole-array erase
  task automatic request(int kind, int addr, bit exp_err, string req);
    @(negedge clk);
    req_prog = (kind == 0); req_erase = (kind == 1); req_chip = (kind == 2);
    op_addr = 19'(addr);
    @(negedge clk);
    req_prog = 0; req_erase = 0; req_chip = 0;
    check({req, " valid"}, int'(rsp_valid), 1);
    check({req, " err"}, int'(rsp_err), int'(exp_err));
    check({req, " ok"}, int'(rsp_ok), int'(!exp_err));
  endtask

  initial begin
    do_reset();
    // R1: all clear after reset
    sweep_ids("R1");
    // R7, R6 unlocked array
    request(2, 0, 1'b0, "R7 chip unlocked");
    for (int s = 0; s < 23; s++) request(0, base_of(s) + 5, 1'b0, "R6 prog unlocked");
    // R11: no response when idle
    @(negedge clk);
    check("R11 idle", int'(rsp_valid), 0);

    // R3, R2: lock with varied offsets, sweep all sectors after each
    lock_at(base_of(3) + 32767);  sweep_ids("R3 R2");
    lock_at(base_of(14) + 100);   sweep_ids("R3 R2");
    lock_at(base_of(15));         sweep_ids("R3 R2");
    lock_at(base_of(22) + 4095);  sweep_ids("R3 R2");
    lock_at(base_of(19) + 2049);  sweep_ids("R3 R2");

    // R4 R5 R6 across all sectors at off-base offsets
    for (int s = 0; s < 23; s++) begin
      int ofs = (s * 37 + 11) % size_of(s);
      request(0, base_of(s) + ofs, model_lock[s], model_lock[s] ? "R4 prog locked" : "R6 prog");
      request(1, base_of(s) + size_of(s) - 1 - ofs, model_lock[s],
              model_lock[s] ? "R5 erase locked" : "R6 erase");
    end
    // R7 locked array
    request(2, 1234, 1'b1, "R7 chip locked");

    // R8: relock of a locked sector
    lock_at(base_of(3) + 7);
    sweep_ids("R8");

    // R9: wrong mode or offset gives 0
    id_read(base_of(3) + 2, 1'b0, 1'b0, "R9 mode off");
    id_read(base_of(3) + 3, 1'b1, 1'b0, "R9 offset 3");
    id_read(base_of(22), 1'b1, 1'b0, "R9 offset 0");
    id_read(base_of(19) + 4096 + 2, 1'b1, 1'b0, "R9 next sector");

    // R11: request in lock cycle judged on old state
    @(negedge clk);
    cmd_lock = 1'b1; req_prog = 1'b1; op_addr = 19'(base_of(7) + 9);
    @(negedge clk);
    cmd_lock = 1'b0; req_prog = 1'b0; model_lock[7] = 1'b1;
    check("R11 same-cycle ok", int'(rsp_ok), 1);
    request(0, base_of(7) + 9, 1'b1, "R11 after lock");

    // R10: persistence over idle time
    repeat (50) @(negedge clk);
    sweep_ids("R10 persist");
    do_reset();
    sweep_ids("R10 reset clears");
    request(2, 0, 1'b0, "R10 chip after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule